// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and drives one IRQ output toward a processor. A small bank of vector slots, ordered by position, each binds one source number to a handler address. When the processor reads the current-vector register it receives the address of the highest-priority eligible request. If a request belongs to no enabled slot, the read returns a shared default address instead. A write of any value to the same register ends service.

Software reaches every register over a simple single-cycle register bus with a privilege qualifier. Through it software sets and clears source enables, forces requests by software for test, programs the slots and the default address, and reads back raw and enabled request status. A protection bit keeps non-privileged code out of all registers. Hardware gives no nesting support: it keeps one service level. A vector read raises that level so that requests of equal or lower priority stay quiet until end of service. The bus has no data stream, so all of its pins are plain control and status signals. A read returns data combinationally in the cycle of the access, and any side effect takes place at the clock edge that closes the access.

Top module: `vec_irq_ctrl`

Register word addresses (on `bus_addr_i`): 0 enabled status (RO), 1 raw request (RO), 2 enable-set (reads enable), 3 enable-clear (reads enable), 4 force-set (reads force), 5 force-clear (reads force), 6 protection (bit 0), 7 current vector, 8 default address, 16+k slot k control, 32+k slot k address.

## Requirements
- R1: After reset, the enable, force, protection and slot control registers and the default address all read 0, `irq_o` is low, and a vector read returns 0.
- R2: A slot control word holds the source number in bits 4:0 and the slot enable in bit 5. Writing 0x20 plus n activates the slot for source n. With bit 5 clear, the slot is ignored, and its source is handled as unslotted.
- R3: Among enabled slots whose source is both requesting and enabled, the lowest slot index wins. A vector read returns the address of that slot.
- R4: If no eligible slot requests, but a requesting enabled source is assigned to no enabled slot, a vector read returns the default address.
- R5: The raw register shows hardware line OR software force for each source. The status register shows raw AND enable.
- R6: Writing the enable-set address sets each enable bit that is 1 in the data. Writing the enable-clear address clears each enable bit that is 1 in the data. A 0 data bit leaves its enable unchanged.
- R7: The force-set and force-clear addresses set and clear per-source software requests in the same way. A forced request acts exactly like the hardware line being high.
- R8: A privileged vector read that returns slot k masks slot k, every higher-numbered slot and the default. One that returns the default masks only the default. A write of any value to the vector address removes all masking.
- R9: While protection is 1, a non-privileged write has no effect and a non-privileged read returns 0 with no side effect. Privileged access is always allowed.
- R10: `irq_o` is high exactly when some unmasked eligible request exists, either an eligible slot or an unmasked default request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Level-sensitive hardware request lines |
| bus_sel_i | input | 1 | Register access valid this cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_priv_i | input | 1 | Access is made in privileged mode |
| bus_addr_i | input | 6 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is a raised service level that has a higher-priority slot still eligible above it, together with lower requests still pending underneath. Reaching it takes a vector read with two slotted sources pending, then a third source raised on a higher slot before end of service. The bench builds it by holding several hardware lines at once and interleaving vector reads, line changes and end-of-service writes. It checks `irq_o` after each step. Protection is checked by sending the same reads and writes with and without privilege, and then reading the state back with privilege.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BUS_AW = 6;
  localparam int BUS_DW = 32;
  localparam int SLOT_EN_BIT = 5;
  localparam int CTL_W = 6;

  localparam logic [BUS_AW-1:0] A_STAT  = 6'd0;
  localparam logic [BUS_AW-1:0] A_RAW   = 6'd1;
  localparam logic [BUS_AW-1:0] A_ENSET = 6'd2;
  localparam logic [BUS_AW-1:0] A_ENCLR = 6'd3;
  localparam logic [BUS_AW-1:0] A_SWSET = 6'd4;
  localparam logic [BUS_AW-1:0] A_SWCLR = 6'd5;
  localparam logic [BUS_AW-1:0] A_PROT  = 6'd6;
  localparam logic [BUS_AW-1:0] A_VEC   = 6'd7;
  localparam logic [BUS_AW-1:0] A_DEF   = 6'd8;
  localparam int A_SCTL_BASE = 16;
  localparam int A_SADR_BASE = 32;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              acc_ok,
  input  logic                              sel,
  input  logic                              wr,
  input  logic [BUS_AW-1:0]                 addr,
  input  logic [BUS_DW-1:0]                 wdata,
  input  logic [NUM_SRC-1:0]                irq_hw,
  input  logic [BUS_DW-1:0]                 vec_adr,
  output logic [BUS_DW-1:0]                 rdata,
  output logic [NUM_SRC-1:0]                act,
  output logic                              prot,
  output logic [NUM_SLOT-1:0][CTL_W-1:0]    slot_ctl,
  output logic [NUM_SLOT-1:0][BUS_DW-1:0]   slot_adr,
  output logic [BUS_DW-1:0]                 def_adr,
  output logic                              vec_rd,
  output logic                              eoi
);
  logic [NUM_SRC-1:0] en_q, sw_q, raw;
  logic wr_ok, rd_ok;

  assign wr_ok  = sel & wr & acc_ok;
  assign rd_ok  = sel & ~wr & acc_ok;
  assign raw    = irq_hw | sw_q;
  assign act    = raw & en_q;
  assign vec_rd = rd_ok & (addr == A_VEC);
  assign eoi    = wr_ok & (addr == A_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sw_q    <= '0;
      prot    <= 1'b0;
      def_adr <= '0;
    end else if (wr_ok) begin
      case (addr)
        A_ENSET: en_q    <= en_q | wdata[NUM_SRC-1:0];
        A_ENCLR: en_q    <= en_q & ~wdata[NUM_SRC-1:0];
        A_SWSET: sw_q    <= sw_q | wdata[NUM_SRC-1:0];
        A_SWCLR: sw_q    <= sw_q & ~wdata[NUM_SRC-1:0];
        A_PROT:  prot    <= wdata[0];
        A_DEF:   def_adr <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    localparam logic [BUS_AW-1:0] CTL_A = BUS_AW'(A_SCTL_BASE + k);
    localparam logic [BUS_AW-1:0] ADR_A = BUS_AW'(A_SADR_BASE + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_ctl[k] <= '0;
        slot_adr[k] <= '0;
      end else if (wr_ok) begin
        if (addr == CTL_A) slot_ctl[k] <= wdata[CTL_W-1:0];
        if (addr == ADR_A) slot_adr[k] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      case (addr)
        A_STAT:           rdata = BUS_DW'(act);
        A_RAW:            rdata = BUS_DW'(raw);
        A_ENSET, A_ENCLR: rdata = BUS_DW'(en_q);
        A_SWSET, A_SWCLR: rdata = BUS_DW'(sw_q);
        A_PROT:           rdata = BUS_DW'(prot);
        A_VEC:            rdata = vec_adr;
        A_DEF:            rdata = def_adr;
        default: begin
          for (int k = 0; k < NUM_SLOT; k++) begin
            if (addr == BUS_AW'(A_SCTL_BASE + k)) rdata = BUS_DW'(slot_ctl[k]);
            if (addr == BUS_AW'(A_SADR_BASE + k)) rdata = slot_adr[k];
          end
        end
      endcase
    end
  end

  p_blocked_wr_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !acc_ok) |=> $stable(en_q) && $stable(sw_q) && $stable(prot));

  p_enclr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == A_ENCLR) |=> ((en_q & $past(wdata[NUM_SRC-1:0])) == '0));

  p_swset_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == A_SWSET) |=> ((raw & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  localparam int SRC_W = $clog2(NUM_SRC),
  localparam int LVL_W = $clog2(NUM_SLOT + 2)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              act,
  input  logic [NUM_SLOT-1:0][CTL_W-1:0]  slot_ctl,
  input  logic [NUM_SLOT-1:0][BUS_DW-1:0] slot_adr,
  input  logic [BUS_DW-1:0]               def_adr,
  input  logic [LVL_W-1:0]                lvl,
  output logic                            irq,
  output logic                            win_any,
  output logic [LVL_W-1:0]                win_lvl,
  output logic [BUS_DW-1:0]               win_adr
);
  localparam logic [LVL_W-1:0] LVL_DEF  = LVL_W'(NUM_SLOT);
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NUM_SLOT + 1);

  logic [NUM_SLOT-1:0] hit, grant;
  logic [NUM_SRC-1:0]  covered, unslotted;
  logic                hit_any, def_req;

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_hit
    logic [SRC_W-1:0] src;
    logic             on;
    assign src    = slot_ctl[k][SRC_W-1:0];
    assign on     = slot_ctl[k][SLOT_EN_BIT];
    assign hit[k] = on & act[src] & (LVL_W'(k) < lvl);
  end

  always_comb begin
    covered = '0;
    for (int k = 0; k < NUM_SLOT; k++)
      if (slot_ctl[k][SLOT_EN_BIT]) covered[slot_ctl[k][SRC_W-1:0]] = 1'b1;
  end

  assign unslotted = act & ~covered;
  assign hit_any   = |hit;
  assign def_req   = (|unslotted) & (lvl == LVL_IDLE);
  assign grant     = hit & ~(hit - NUM_SLOT'(1));

  always_comb begin
    win_lvl = LVL_DEF;
    win_adr = def_adr;
    for (int k = NUM_SLOT - 1; k >= 0; k--) begin
      if (hit[k]) begin
        win_lvl = LVL_W'(k);
        win_adr = slot_adr[k];
      end
    end
  end

  assign win_any = hit_any | def_req;
  assign irq     = win_any;

  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (hit_any == (grant != '0)));

  p_winner_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (win_lvl < lvl));

  p_default_needs_unslotted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_any && !hit_any) |-> (|unslotted));
endmodule

// File: rtl/vic_level.sv
module vic_level #(
  parameter int NUM_SLOT = 16,
  localparam int LVL_W = $clog2(NUM_SLOT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_rd,
  input  logic             eoi,
  input  logic             win_any,
  input  logic [LVL_W-1:0] win_lvl,
  output logic [LVL_W-1:0] lvl
);
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NUM_SLOT + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lvl <= LVL_IDLE;
    else if (eoi)               lvl <= LVL_IDLE;
    else if (vec_rd && win_any) lvl <= win_lvl;
  end

  p_eoi_unmasks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> (lvl == LVL_IDLE));

  p_level_only_rises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> ((lvl < $past(lvl)) || (lvl == LVL_IDLE)));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  localparam int LVL_W = $clog2(NUM_SLOT + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_src_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_priv_i,
  input  logic [BUS_AW-1:0]    bus_addr_i,
  input  logic [BUS_DW-1:0]    bus_wdata_i,
  output logic [BUS_DW-1:0]    bus_rdata_o,
  output logic                 irq_o
);
  logic [NUM_SRC-1:0]              act;
  logic                            prot, acc_ok, vec_rd, eoi, win_any;
  logic [NUM_SLOT-1:0][CTL_W-1:0]  slot_ctl;
  logic [NUM_SLOT-1:0][BUS_DW-1:0] slot_adr;
  logic [BUS_DW-1:0]               def_adr, win_adr;
  logic [LVL_W-1:0]                lvl, win_lvl;

  assign acc_ok = ~prot | bus_priv_i;

  vic_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_ok(acc_ok), .sel(bus_sel_i), .wr(bus_wr_i),
    .addr(bus_addr_i), .wdata(bus_wdata_i), .irq_hw(irq_src_i), .vec_adr(win_adr),
    .rdata(bus_rdata_o), .act(act), .prot(prot), .slot_ctl(slot_ctl),
    .slot_adr(slot_adr), .def_adr(def_adr), .vec_rd(vec_rd), .eoi(eoi)
  );

  vic_arb #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_arb (
    .clk(clk), .rst_n(rst_n), .act(act), .slot_ctl(slot_ctl), .slot_adr(slot_adr),
    .def_adr(def_adr), .lvl(lvl), .irq(irq_o), .win_any(win_any),
    .win_lvl(win_lvl), .win_adr(win_adr)
  );

  vic_level #(.NUM_SLOT(NUM_SLOT)) u_level (
    .clk(clk), .rst_n(rst_n), .vec_rd(vec_rd), .eoi(eoi), .win_any(win_any),
    .win_lvl(win_lvl), .lvl(lvl)
  );

  p_irq_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|act));

  p_blocked_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_wr_i && prot && !bus_priv_i) |-> (bus_rdata_o == '0));
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int NSRC = 32;
  localparam int NSLOT = 4;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] hw = '0;
  logic sel = 0, wr = 0, priv = 1;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int tests = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(NSRC), .NUM_SLOT(NSLOT)) i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src_i(hw), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_priv_i(priv), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic bwr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic brd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #(CLK_P/4) d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic chk_irq(string req, logic e);
    @(negedge clk); #1 chk(req, {31'b0, irq}, {31'b0, e});
  endtask

  function automatic logic [4:0] slot_src(int k);
    return 5'((k * 7 + 3) % 32);
  endfunction

  logic [31:0] d;

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    brd(6'd2, d); chk("R1 enable", d, 0);
    brd(6'd4, d); chk("R1 force", d, 0);
    brd(6'd6, d); chk("R1 protect", d, 0);
    brd(6'd16, d); chk("R1 slot ctl", d, 0);
    brd(6'd8, d); chk("R1 default", d, 0);
    brd(6'd7, d); chk("R1 vector", d, 0);
    chk_irq("R1 irq", 0);

    // R6 enable set/clear
    bwr(6'd2, 32'h0000_00A5); brd(6'd2, d); chk("R6 set", d, 32'hA5);
    bwr(6'd2, 32'h0000_000F); brd(6'd3, d); chk("R6 set zero bits", d, 32'hAF);
    bwr(6'd3, 32'h0000_0005); brd(6'd2, d); chk("R6 clear", d, 32'hAA);
    bwr(6'd3, 32'hFFFF_FFFF); brd(6'd2, d); chk("R6 clear all", d, 0);

    // R5 / R7 sweep over every source
    for (int s = 0; s < NSRC; s++) begin
      hw = 32'(1) << s;
      brd(6'd1, d); chk("R5 raw hw", d, 32'(1) << s);
      brd(6'd0, d); chk("R5 status disabled", d, 0);
      bwr(6'd2, 32'(1) << s);
      brd(6'd0, d); chk("R5 status enabled", d, 32'(1) << s);
      hw = '0;
      bwr(6'd4, 32'(1) << s);
      brd(6'd1, d); chk("R7 forced raw", d, 32'(1) << s);
      brd(6'd0, d); chk("R7 forced status", d, 32'(1) << s);
      bwr(6'd5, 32'(1) << s);
      brd(6'd4, d); chk("R7 force clear", d, 0);
      bwr(6'd3, 32'(1) << s);
    end

    // R4 default vector sweep
    bwr(6'd8, 32'hD000_0000);
    bwr(6'd2, 32'hFFFF_FFFF);
    for (int s = 0; s < NSRC; s++) begin
      hw = 32'(1) << s;
      chk_irq("R10 unslotted irq", 1);
      brd(6'd7, d); chk("R4 default vector", d, 32'hD000_0000);
      chk_irq("R8 default masked", 0);
      bwr(6'd7, 32'h1234);
      chk_irq("R8 eoi restores", 1);
    end
    hw = '0;
    chk_irq("R10 idle", 0);

    // R2 / R3 slots
    for (int k = 0; k < NSLOT; k++) begin
      bwr(6'(16 + k), 32'h20 | 32'(slot_src(k)));
      bwr(6'(32 + k), 32'h1000 + 32'(k) * 32'h10);
    end
    brd(6'd17, d); chk("R2 ctl readback", d, 32'h20 | 32'(slot_src(1)));
    for (int m = 0; m < 16; m++) begin
      logic [31:0] exp_a;
      int w;
      hw = '0; w = -1;
      for (int k = NSLOT - 1; k >= 0; k--)
        if (m[k]) begin hw[slot_src(k)] = 1'b1; w = k; end
      exp_a = (w < 0) ? 32'hD000_0000 : 32'h1000 + 32'(w) * 32'h10;
      chk_irq("R10 slot irq", m != 0);
      if (m != 0) begin
        brd(6'd7, d); chk("R3 priority winner", d, exp_a);
        bwr(6'd7, 0);
      end
    end
    // slot with enable bit clear is ignored
    bwr(6'd18, 32'h0000_0005);
    hw = 32'(1) << 5;
    brd(6'd7, d); chk("R2 disabled slot falls to default", d, 32'hD000_0000);
    bwr(6'd7, 0);
    bwr(6'd18, 32'h0000_0025);
    brd(6'd7, d); chk("R2 0x20 plus source activates", d, 32'h1020);
    bwr(6'd7, 0);
    bwr(6'd18, 32'h20 | 32'(slot_src(2)));

    // R8 masking scenario
    hw = '0; hw[slot_src(1)] = 1; hw[slot_src(2)] = 1;
    brd(6'd7, d); chk("R8 first read slot1", d, 32'h1010);
    chk_irq("R8 lower slots masked", 0);
    hw[slot_src(0)] = 1;
    chk_irq("R8 higher slot raises irq", 1);
    brd(6'd7, d); chk("R8 higher slot wins", d, 32'h1000);
    chk_irq("R8 all masked", 0);
    hw[slot_src(0)] = 0;
    bwr(6'd7, 32'hFFFF_FFFF);
    chk_irq("R8 eoi irq", 1);
    brd(6'd7, d); chk("R8 slot1 again", d, 32'h1010);
    bwr(6'd7, 0);
    hw = '0; hw[9] = 1;
    brd(6'd7, d); chk("R8 default read", d, 32'hD000_0000);
    chk_irq("R8 default masked", 0);
    hw[slot_src(3)] = 1;
    chk_irq("R8 slot above default", 1);
    brd(6'd7, d); chk("R8 slot3 preempts default", d, 32'h1030);
    bwr(6'd7, 0);
    hw = '0;

    // R9 protection
    bwr(6'd6, 1);
    priv = 0;
    bwr(6'd3, 32'hFFFF_FFFF);
    bwr(6'd6, 0);
    brd(6'd2, d); chk("R9 user read zero", d, 0);
    priv = 1;
    brd(6'd2, d); chk("R9 user write ignored", d, 32'hFFFF_FFFF);
    brd(6'd6, d); chk("R9 protect kept", d, 1);
    hw[slot_src(1)] = 1;
    priv = 0;
    brd(6'd7, d); chk("R9 user vector zero", d, 0);
    chk_irq("R9 user read no mask", 1);
    bwr(6'd18, 32'h0);
    priv = 1;
    brd(6'd18, d); chk("R9 slot unchanged", d, 32'h20 | 32'(slot_src(2)));
    brd(6'd7, d); chk("R9 priv vector", d, 32'h1010);
    bwr(6'd7, 0);
    bwr(6'd6, 0);
    priv = 0;
    brd(6'd2, d); chk("R9 unprotected user read", d, 32'hFFFF_FFFF);
    priv = 1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule